// File: doc/BRIEF.md
# Half-Duplex Serial ADC Host Controller

This block runs single conversions on an 8-bit serial analog-to-digital converter that shares one bidirectional data pin for both command and result. A request carries two mode flags: single-ended versus differential, and channel select or polarity. When a request is accepted, the controller pulls chip select low, which also wakes the converter. It waits a programmable wake-up time and then generates a divided serial clock. On that clock it sends a four-bit command, hands the data pin over to the converter, and reads back a null bit followed by eight result bits, most significant first.

Chip select doubles as the converter's power-down control, so the controller raises it on the serial clock's falling edge that closes the frame. It does not wait for the consumer of the result. The result goes into a held output register with a valid/ready handshake. The result, its framing flag and the valid strobe stay unchanged until `res_ready` is seen high. No new request is accepted while a result is still waiting. Back-pressure therefore stalls the next conversion but never stretches chip-select low time.

Requests use valid/ready. A request is taken on a clock edge where both `req_valid` and `req_ready` are high. When `req_ready` is low, `req_valid` is ignored. The data pin is split into `adc_dio_o`, `adc_dio_oe` and `adc_dio_i` so that the pad's tri-state buffer sits outside the block. `HALF_DIV` must be at least 2 and `WAKE_CYCLES` at least 1. With the defaults at a 50 MHz system clock, the serial clock runs at 500 kHz and the wake-up time is 10 µs.

Top module: `sadc_host_ctrl`

## Requirements
- R1: After reset: `adc_cs_n`=1, `adc_sclk`=0, `adc_dio_oe`=0, `busy`=0, `res_valid`=0, `req_ready`=1.
- R2: `req_ready` is high only when no conversion is running and no result is pending. A request offered while `busy` is high starts no conversion. `busy` equals the inverse of `adc_cs_n`.
- R3: The first rising edge of `adc_sclk` comes exactly `WAKE_CYCLES`+`HALF_DIV` system cycles after `adc_cs_n` falls. This includes a low half-phase after the wake-up count.
- R4: While `adc_cs_n` is low, every high and every low phase of `adc_sclk` lasts exactly `HALF_DIV` system cycles.
- R5: At serial rising edges 1 to 4, `adc_dio_oe`=1 and `adc_dio_o` carries, in this order: 1 (start), the single-ended flag, the channel/polarity flag, and 1 (most-significant-first select).
- R6: `adc_dio_oe` goes low exactly one system cycle after the 4th serial rising edge. This is inside the high phase that precedes the 4th falling edge. It stays low for the rest of the frame.
- R7: The bits on `adc_dio_i` sampled at serial rising edges 6 to 13 form `res_data`, with bit 7 taken first.
- R8: `res_ferr` is 1 exactly when the bit sampled at serial rising edge 5 (the null bit) is 1.
- R9: A frame has exactly 13 serial rising edges. `adc_cs_n` returns high in the same cycle as the falling edge that follows the 13th rise. `res_valid` rises and `busy` falls in that same cycle.
- R10: While `res_valid`=1 and `res_ready`=0, `res_valid`, `res_data` and `res_ferr` hold their values and no new conversion starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Conversion request offered |
| req_ready | output | 1 | Controller can take a request |
| req_sgl | input | 1 | 1 = single-ended input, 0 = differential |
| req_odd | input | 1 | Channel select / polarity flag |
| res_valid | output | 1 | Result held and waiting |
| res_ready | input | 1 | Consumer takes the result |
| res_data | output | 8 | Conversion result |
| res_ferr | output | 1 | Null bit was not 0 |
| busy | output | 1 | Conversion in progress (chip select low) |
| adc_cs_n | output | 1 | Converter chip select, low active; high = shutdown |
| adc_sclk | output | 1 | Serial clock to converter |
| adc_dio_o | output | 1 | Data pin value while host drives |
| adc_dio_oe | output | 1 | Host drive enable for the data pin |
| adc_dio_i | input | 1 | Data pin value read back |

## Verification
A converter model in the bench walks all four combinations of the two mode flags. It pairs them with result patterns that alternate bits (A5, 3C), sit at both extremes (00, FF) and set only the end bits (81). These separate a swapped or shifted command bit, an inverted or off-by-one result shift, and a stuck sample. One frame returns a null bit of 1, so a framing flag that is wired to the wrong sample or never set shows up. A stalled consumer, together with requests offered during a conversion, shows whether back-pressure and the busy interval really block a second chip-select cycle. In every frame the bench times the wake-up interval, each clock phase and the exact cycle of the data-pin release.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
  localparam int CMD_BITS    = 4;
  localparam int RES_BITS    = 8;
  localparam int RX_BITS     = RES_BITS + 1;
  localparam int RISES_TOTAL = CMD_BITS + RX_BITS;
  localparam int RISE_W      = $clog2(RISES_TOTAL + 1);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAKE  = 2'd1,
    ST_SHIFT = 2'd2
  } sadc_state_t;

  // start bit, input mode, channel/polarity, msb-first select (always 1)
  function automatic logic [CMD_BITS-1:0] sadc_build_cmd(input logic sgl, input logic odd);
    return {1'b1, sgl, odd, 1'b1};
  endfunction
endpackage

// File: rtl/sadc_sclk_div.sv
module sadc_sclk_div #(
  parameter int HALF_DIV = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;

  assign tick = en && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (!en)      cnt <= '0;
    else if (tick)     cnt <= '0;
    else               cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sadc_wake_timer.sv
module sadc_wake_timer #(
  parameter int WAKE_CYCLES = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic done
);
  generate
    if (WAKE_CYCLES <= 1) begin : g_single
      assign done = en;
    end else begin : g_count
      localparam int CW = $clog2(WAKE_CYCLES);
      localparam logic [CW-1:0] LAST = CW'(WAKE_CYCLES - 1);
      logic [CW-1:0] cnt;
      assign done = en && (cnt == LAST);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt <= '0;
        else if (!en)   cnt <= '0;
        else if (!done) cnt <= cnt + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/sadc_rx_shift.sv
module sadc_rx_shift #(
  parameter int WIDTH = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             shift,
  input  logic             din,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= '0;
    else if (clr)    q <= '0;
    else if (shift)  q <= {q[WIDTH-2:0], din};
  end
endmodule

// File: rtl/sadc_host_ctrl.sv
module sadc_host_ctrl
  import sadc_pkg::*;
#(
  parameter int HALF_DIV    = 50,
  parameter int WAKE_CYCLES = 500
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_sgl,
  input  logic                req_odd,
  output logic                res_valid,
  input  logic                res_ready,
  output logic [RES_BITS-1:0] res_data,
  output logic                res_ferr,
  output logic                busy,
  output logic                adc_cs_n,
  output logic                adc_sclk,
  output logic                adc_dio_o,
  output logic                adc_dio_oe,
  input  logic                adc_dio_i
);
  localparam logic [RISE_W-1:0] RISE_RELEASE = RISE_W'(CMD_BITS);
  localparam logic [RISE_W-1:0] RISE_LAST    = RISE_W'(RISES_TOTAL);

  sadc_state_t         state;
  logic [CMD_BITS-1:0] cmd_q;
  logic [RISE_W-1:0]   rise_cnt;
  logic [RISE_W-1:0]   rise_next;
  logic                sclk_q, cs_n_q, dout_q, oe_q, rel_pend;
  logic                rv_q, ferr_q;
  logic [RES_BITS-1:0] data_q;
  logic [RX_BITS-1:0]  rx_q;
  logic                accept, tick, wake_done;
  logic                rise_tick, fall_tick, rx_shift;

  assign req_ready = (state == ST_IDLE) && !rv_q;
  assign accept    = req_valid && req_ready;
  assign rise_next = rise_cnt + 1'b1;
  assign rise_tick = (state == ST_SHIFT) && tick && !sclk_q;
  assign fall_tick = (state == ST_SHIFT) && tick && sclk_q;
  assign rx_shift  = rise_tick && (rise_next > RISE_RELEASE);

  sadc_sclk_div #(.HALF_DIV(HALF_DIV)) div_i (
    .clk(clk), .rst_n(rst_n), .en(state == ST_SHIFT), .tick(tick)
  );

  sadc_wake_timer #(.WAKE_CYCLES(WAKE_CYCLES)) wake_i (
    .clk(clk), .rst_n(rst_n), .en(state == ST_WAKE), .done(wake_done)
  );

  sadc_rx_shift #(.WIDTH(RX_BITS)) rx_i (
    .clk(clk), .rst_n(rst_n), .clr(accept), .shift(rx_shift),
    .din(adc_dio_i), .q(rx_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cmd_q    <= '0;
      rise_cnt <= '0;
      sclk_q   <= 1'b0;
      cs_n_q   <= 1'b1;
      dout_q   <= 1'b0;
      oe_q     <= 1'b0;
      rel_pend <= 1'b0;
      rv_q     <= 1'b0;
      ferr_q   <= 1'b0;
      data_q   <= '0;
    end else begin
      if (rv_q && res_ready) rv_q <= 1'b0;
      rel_pend <= 1'b0;
      if (rel_pend) begin
        oe_q   <= 1'b0;
        dout_q <= 1'b0;
      end
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            cmd_q    <= sadc_build_cmd(req_sgl, req_odd);
            dout_q   <= 1'b1;
            oe_q     <= 1'b1;
            cs_n_q   <= 1'b0;
            rise_cnt <= '0;
            state    <= ST_WAKE;
          end
        end
        ST_WAKE: begin
          if (wake_done) state <= ST_SHIFT;
        end
        ST_SHIFT: begin
          if (rise_tick) begin
            sclk_q   <= 1'b1;
            rise_cnt <= rise_next;
            if (rise_next == RISE_RELEASE) rel_pend <= 1'b1;
          end else if (fall_tick) begin
            sclk_q <= 1'b0;
            if (rise_cnt == RISE_LAST) begin
              cs_n_q <= 1'b1;
              rv_q   <= 1'b1;
              data_q <= rx_q[RES_BITS-1:0];
              ferr_q <= rx_q[RX_BITS-1];
              state  <= ST_IDLE;
            end else if (rise_cnt < RISE_RELEASE) begin
              dout_q <= cmd_q[CMD_BITS-2];
              cmd_q  <= {cmd_q[CMD_BITS-2:0], 1'b0};
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy       = (state != ST_IDLE);
  assign adc_cs_n   = cs_n_q;
  assign adc_sclk   = sclk_q;
  assign adc_dio_o  = dout_q;
  assign adc_dio_oe = oe_q;
  assign res_valid  = rv_q;
  assign res_data   = data_q;
  assign res_ferr   = ferr_q;
endmodule

// File: rtl/sadc_host_ctrl_chk.sv
module sadc_host_ctrl_chk #(
  parameter int HALF_DIV = 50
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       sclk,
  input logic       oe,
  input logic       busy,
  input logic       req_ready,
  input logic       res_valid,
  input logic       res_ready,
  input logic [7:0] res_data,
  input logic       res_ferr
);
  logic        sclk_q;
  logic [15:0] stable_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q     <= 1'b0;
      stable_cnt <= '0;
    end else begin
      sclk_q <= sclk;
      if (sclk != sclk_q)            stable_cnt <= '0;
      else if (stable_cnt != 16'hFFFF) stable_cnt <= stable_cnt + 1'b1;
    end
  end

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (!sclk && !oe));

  assert_busy_cs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy == !cs_n);

  assert_ready_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!busy && !res_valid));

  assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data) && $stable(res_ferr)));

  assert_phase_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && (sclk != sclk_q)) |-> (stable_cnt >= 16'(HALF_DIV - 1)));

  assert_release_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oe) |-> (sclk && !cs_n));
endmodule

bind sadc_host_ctrl sadc_host_ctrl_chk #(.HALF_DIV(HALF_DIV)) chk_i (
  .clk(clk), .rst_n(rst_n), .cs_n(adc_cs_n), .sclk(adc_sclk), .oe(adc_dio_oe),
  .busy(busy), .req_ready(req_ready), .res_valid(res_valid), .res_ready(res_ready),
  .res_data(res_data), .res_ferr(res_ferr)
);

// File: tb/sadc_host_ctrl_tb_top.sv
`timescale 1ns/1ps
module sadc_host_ctrl_tb_top;
  localparam int HALF = 3;
  localparam int WAKE = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_sgl = 1'b0, req_odd = 1'b0, res_ready = 1'b1;
  logic adc_dio_i = 1'b1;
  logic req_ready, res_valid, res_ferr, busy, adc_cs_n, adc_sclk, adc_dio_o, adc_dio_oe;
  logic [7:0] res_data;

  always #10 clk = ~clk;

  sadc_host_ctrl #(.HALF_DIV(HALF), .WAKE_CYCLES(WAKE)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_sgl(req_sgl), .req_odd(req_odd), .res_valid(res_valid), .res_ready(res_ready),
    .res_data(res_data), .res_ferr(res_ferr), .busy(busy), .adc_cs_n(adc_cs_n),
    .adc_sclk(adc_sclk), .adc_dio_o(adc_dio_o), .adc_dio_oe(adc_dio_oe), .adc_dio_i(adc_dio_i)
  );

  typedef struct { bit sgl; bit odd; logic [7:0] data; bit nul; } conv_t;
  conv_t      model_q[$];
  logic [8:0] exp_q[$];

  int tests = 0, fails = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // converter model, sampled away from the active edge
  conv_t cur;
  int cyc = 0, cs_fall_cyc = 0, last_edge = 0, rise4_cyc = -10, rise_n = 0, n_cs_fall = 0;
  bit prev_cs = 1'b1, prev_sclk = 1'b0, phase_bad = 1'b0;
  logic [3:0] cmd_exp;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (prev_cs && !adc_cs_n) begin
        n_cs_fall++;
        if (model_q.size() > 0) cur = model_q.pop_front();
        cmd_exp = {1'b1, cur.sgl, cur.odd, 1'b1};
        rise_n = 0; cs_fall_cyc = cyc; last_edge = cyc; phase_bad = 0; adc_dio_i = 1'b1;
      end
      if (!adc_cs_n && adc_sclk && !prev_sclk) begin
        rise_n++;
        if (rise_n == 1)
          chk(cyc - cs_fall_cyc == WAKE + HALF, "R3 wake-to-first-rise", cyc - cs_fall_cyc, WAKE + HALF);
        else if (cyc - last_edge != HALF) phase_bad = 1;
        last_edge = cyc;
        if (rise_n <= 4)
          chk(adc_dio_oe && adc_dio_o == cmd_exp[4-rise_n], "R5 command bit",
              {adc_dio_oe, adc_dio_o}, {1'b1, cmd_exp[4-rise_n]});
        if (rise_n == 4) rise4_cyc = cyc;
      end
      if (!adc_cs_n && rise_n == 4 && cyc == rise4_cyc + 1)
        chk(!adc_dio_oe && adc_sclk, "R6 release one cycle after 4th rise", adc_dio_oe, 0);
      if (!adc_cs_n && !adc_sclk && prev_sclk) begin
        if (cyc - last_edge != HALF) phase_bad = 1;
        last_edge = cyc;
        if (rise_n == 4) adc_dio_i = cur.nul;
        else if (rise_n >= 5 && rise_n <= 12) adc_dio_i = cur.data[12-rise_n];
        if (rise_n > 4 && adc_dio_oe) phase_bad = 1;
      end
      if (!prev_cs && adc_cs_n) begin
        if (cyc - last_edge != HALF) phase_bad = 1;
        chk(!phase_bad, "R4 clock phase length / oe low after release", phase_bad, 0);
        chk(rise_n == 13 && !adc_sclk && res_valid && !busy, "R9 frame end",
            {rise_n[7:0], adc_sclk, res_valid, busy}, {8'd13, 3'b010});
        adc_dio_i = 1'b1;
      end
    end
    prev_cs = adc_cs_n;
    prev_sclk = adc_sclk;
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && res_valid && res_ready) begin
      if (exp_q.size() == 0) chk(0, "R7 unexpected result", res_data, 0);
      else begin
        logic [8:0] e;
        e = exp_q.pop_front();
        chk(res_data == e[7:0], "R7 result data", res_data, e[7:0]);
        chk(res_ferr == e[8], "R8 framing flag", res_ferr, e[8]);
      end
    end
  end

  task automatic run_conv(input bit sgl, input bit odd, input logic [7:0] data,
                          input bit nul, input bit poke);
    conv_t c;
    c.sgl = sgl; c.odd = odd; c.data = data; c.nul = nul;
    model_q.push_back(c);
    exp_q.push_back({nul, data});
    do @(negedge clk); while (!req_ready);
    req_valid = 1'b1; req_sgl = sgl; req_odd = odd;
    @(negedge clk);
    req_valid = 1'b0;
    if (poke) begin
      repeat (5) @(negedge clk);
      req_valid = 1'b1; req_sgl = ~sgl;
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        chk(!req_ready && busy, "R2 not ready while busy", req_ready, 0);
      end
      req_valid = 1'b0;
    end
    while (!adc_cs_n) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(adc_cs_n && !adc_sclk && !adc_dio_oe && !busy && !res_valid && req_ready, "R1 reset state",
        {adc_cs_n, adc_sclk, adc_dio_oe, busy, res_valid, req_ready}, 6'b100001);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(adc_cs_n && !busy && req_ready, "R1 idle after reset", {adc_cs_n, busy, req_ready}, 3'b101);

    run_conv(1, 0, 8'hA5, 0, 0);
    run_conv(0, 1, 8'h3C, 0, 1);
    run_conv(1, 1, 8'h00, 0, 0);
    run_conv(0, 0, 8'hFF, 0, 0);
    run_conv(1, 0, 8'h81, 1, 0);

    // R10: stalled consumer
    res_ready = 1'b0;
    run_conv(0, 1, 8'h5A, 0, 0);
    begin
      bit held = 1;
      logic [7:0] d0;
      d0 = res_data;
      req_valid = 1'b1;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (!res_valid || res_data != d0 || !adc_cs_n || req_ready) held = 0;
      end
      req_valid = 1'b0;
      chk(held, "R10 result held, no new conversion", held, 1);
      chk(d0 == 8'h5A, "R10 held value", d0, 8'h5A);
    end
    @(negedge clk);
    res_ready = 1'b1;
    repeat (4) @(negedge clk);

    chk(n_cs_fall == 6, "R2 ignored requests start nothing", n_cs_fall, 6);
    chk(exp_q.size() == 0, "R7 all results delivered", exp_q.size(), 0);
    chk(!res_valid && req_ready, "R10 released after accept", {res_valid, req_ready}, 2'b01);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule